// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It handles register-to-register arithmetic and logic (add, subtract, AND, OR, set-on-less-than), word loads and stores, branch-on-equal, a jump through a register and the load of an upper immediate. The core holds a 32-entry register file, an ALU with its own function decoder, a main instruction decoder and next-PC logic. It also has two small internal word memories, one for instructions and one for data. Both have synchronous writes and combinational reads.

The main decoder sorts each opcode into an instruction class using a `unique case`. The classes are NONE, ALU, LOAD, STORE, BRANCH, JREG and UPPER. Each class sets one fixed control word. A register-jump select drives its own next-PC multiplexer. An upper-immediate select drives its own write-back multiplexer. Every control bit that has no meaning for a class is driven to 0.

The test environment uses a word-wide load port to fill both memories while reset is held. It then releases reset and watches the PC. Register and data-memory contents are read back through two combinational inspection ports.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high, the PC is 0 and every register reads 0. On the first clock after `rst` falls, the instruction at address 0 executes.
- R2: R-type instructions (opcode 0x00) write rd with the ALU result. The funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A set-less-than, where set-less-than compares as signed and writes 1 or 0.
- R3: A load word (opcode 0x23) writes rt with the data-memory word at rs plus the sign-extended 16-bit immediate. The byte address is used as a word index with bits 1:0 dropped.
- R4: A store word (opcode 0x2B) writes rt to the data-memory word at rs plus the sign-extended immediate, and it writes no register.
- R5: A branch-on-equal (opcode 0x04) sets the PC to PC+4 plus the sign-extended immediate times 4 when rs equals rt. Otherwise the PC becomes PC+4.
- R6: A register jump (opcode 0x00 with funct 0x08) loads the PC from rs and writes no register and no memory.
- R7: A load-upper-immediate (opcode 0x0F) writes rt with the immediate in bits 31:16 and zeros in bits 15:0.
- R8: Register 0 always reads as 0, including after an instruction that names it as its destination.
- R9: Every instruction that is not a taken branch or a register jump advances the PC by exactly 4 per clock.
- R10: An opcode outside the supported set (for example 0x08) writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Write strobe of the memory load port |
| prog_dmem | input | 1 | Load port target: 1 = data memory, 0 = instruction memory |
| prog_addr | input | 6 | Load port word index |
| prog_wdata | input | 32 | Load port write data |
| pc_o | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register number to inspect |
| peek_reg_val | output | 32 | Contents of the inspected register |
| peek_mem_sel | input | 6 | Data-memory word index to inspect |
| peek_mem_val | output | 32 | Contents of the inspected data-memory word |

## Verification
A wrong control word or a wrong next-PC choice shows on `pc_o` at the very next edge. A branch or jump that goes to the wrong place puts an off-trace PC value on the port one cycle after the instruction, and the bench compares the PC on every cycle. A write-back or memory fault, such as a store that also writes a register or a write to register 0, does not change the PC. It shows only when the inspection ports read the affected register or word after the program has settled into its final self-loop. Each program therefore ends by checking every destination register and every stored word.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LUI   = 6'h0F;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;
    localparam logic [5:0] FN_JR  = 6'h08;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        AF_ADD, AF_SUB, AF_AND, AF_OR, AF_SLT
    } alufn_e;

    typedef enum logic [2:0] {
        IC_NONE, IC_ALU, IC_LOAD, IC_STORE, IC_BRANCH, IC_JREG, IC_UPPER
    } iclass_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        aluop_e alu_op;
        logic   jr_sel;
        logic   lui_sel;
    } ctrl_t;

endpackage

// File: rtl/scpu_ctrl.sv
module scpu_ctrl
    import scpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output iclass_e    iclass,
    output ctrl_t      ctl
);

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: iclass = (funct == FN_JR) ? IC_JREG : IC_ALU;
            OPC_LW:    iclass = IC_LOAD;
            OPC_SW:    iclass = IC_STORE;
            OPC_BEQ:   iclass = IC_BRANCH;
            OPC_LUI:   iclass = IC_UPPER;
            default:   iclass = IC_NONE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (iclass)
            IC_ALU: begin
                ctl.reg_dst   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_op    = AOP_FUNCT;
            end
            IC_LOAD: begin
                ctl.alu_src    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_write  = 1'b1;
                ctl.mem_read   = 1'b1;
            end
            IC_STORE: begin
                ctl.alu_src   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            IC_BRANCH: begin
                ctl.branch = 1'b1;
                ctl.alu_op = AOP_SUB;
            end
            IC_JREG: begin
                ctl.jr_sel = 1'b1;
            end
            IC_UPPER: begin
                ctl.reg_write = 1'b1;
                ctl.lui_sel   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = 32
) (
    input  aluop_e       alu_op,
    input  logic [5:0]   funct,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    alufn_e fn;

    always_comb begin
        unique case (alu_op)
            AOP_ADD: fn = AF_ADD;
            AOP_SUB: fn = AF_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_SUB:  fn = AF_SUB;
                    FN_AND:  fn = AF_AND;
                    FN_OR:   fn = AF_OR;
                    FN_SLT:  fn = AF_SLT;
                    default: fn = AF_ADD;
                endcase
            end
            default: fn = AF_ADD;
        endcase
    end

    always_comb begin
        unique case (fn)
            AF_SUB:  y = a - b;
            AF_AND:  y = a & b;
            AF_OR:   y = a | b;
            AF_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);

    logic [NREGS-1:0][W-1:0] regs;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_hardzero
            assign regs[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && waddr == AW'(g)) begin
                    q <= wdata;
                end
            end
            assign regs[g] = q;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

endmodule

// File: rtl/scpu_core.sv
module scpu_core
    import scpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int W    = 32,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int PA_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic            prog_dmem,
    input  logic [PA_W-1:0] prog_addr,
    input  logic [W-1:0]    prog_wdata,
    output logic [W-1:0]    pc_o,
    input  logic [4:0]      peek_reg_sel,
    output logic [W-1:0]    peek_reg_val,
    input  logic [DA_W-1:0] peek_mem_sel,
    output logic [W-1:0]    peek_mem_val
);

    logic [W-1:0] imem [IMEM_WORDS];
    logic [W-1:0] dmem [DMEM_WORDS];
    logic [W-1:0] pc_q, pc_next;

    logic [W-1:0] instr;
    logic [5:0]   opcode, funct;
    logic [4:0]   rs_idx, rt_idx, rd_idx;
    logic [15:0]  imm16;
    logic [W-1:0] imm_sext;

    iclass_e iclass;
    ctrl_t   ctl;

    logic [W-1:0]    rs_val, rt_val, alu_b, alu_res, wb_data, dm_rdata;
    logic            alu_zero, take_branch, rf_we, dm_we, jr_sel;
    logic [4:0]      rf_waddr;
    logic [DA_W-1:0] dm_idx;

    // fetch and field split
    assign instr    = imem[pc_q[IA_W+1:2]];
    assign opcode   = instr[31:26];
    assign rs_idx   = instr[25:21];
    assign rt_idx   = instr[20:16];
    assign rd_idx   = instr[15:11];
    assign funct    = instr[5:0];
    assign imm16    = instr[15:0];
    assign imm_sext = {{(W-16){imm16[15]}}, imm16};

    scpu_ctrl u_ctrl (
        .opcode (opcode),
        .funct  (funct),
        .iclass (iclass),
        .ctl    (ctl)
    );

    scpu_regfile #(.NREGS(32), .W(W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (wb_data),
        .ra1   (rs_idx),
        .ra2   (rt_idx),
        .ra3   (peek_reg_sel),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (peek_reg_val)
    );

    assign alu_b = ctl.alu_src ? imm_sext : rt_val;

    scpu_alu #(.W(W)) u_alu (
        .alu_op (ctl.alu_op),
        .funct  (funct),
        .a      (rs_val),
        .b      (alu_b),
        .y      (alu_res),
        .zero   (alu_zero)
    );

    // data memory
    assign dm_idx   = alu_res[DA_W+1:2];
    assign dm_rdata = ctl.mem_read ? dmem[dm_idx] : '0;
    assign dm_we    = ctl.mem_write && !rst;

    always_ff @(posedge clk) begin
        if (prog_we && prog_dmem) begin
            dmem[prog_addr[DA_W-1:0]] <= prog_wdata;
        end else if (dm_we) begin
            dmem[dm_idx] <= rt_val;
        end
        if (prog_we && !prog_dmem) begin
            imem[prog_addr[IA_W-1:0]] <= prog_wdata;
        end
    end

    assign peek_mem_val = dmem[peek_mem_sel];

    // write-back
    assign rf_we    = ctl.reg_write && !rst;
    assign rf_waddr = ctl.reg_dst ? rd_idx : rt_idx;

    always_comb begin
        if (ctl.lui_sel) begin
            wb_data = {imm16, 16'h0000};
        end else if (ctl.mem_to_reg) begin
            wb_data = dm_rdata;
        end else begin
            wb_data = alu_res;
        end
    end

    // next PC
    assign jr_sel      = ctl.jr_sel;
    assign take_branch = ctl.branch && alu_zero;

    always_comb begin
        if (ctl.jr_sel) begin
            pc_next = rs_val;
        end else if (take_branch) begin
            pc_next = pc_q + 32'd4 + {imm_sext[W-3:0], 2'b00};
        end else begin
            pc_next = pc_q + 32'd4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic        jr_sel,
    input logic        take_branch,
    input logic        rf_we,
    input logic        dm_we,
    input logic        store_op,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val
);

    // R1: the PC starts at zero when reset is released
    a_r1_pc_from_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_o == 32'd0);

    // R9: sequential flow steps by one word per clock
    a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
        (!jr_sel && !take_branch) |=> pc_o == $past(pc_o) + 32'd4);

    // R6: a register jump lands on the register value
    a_r6_jr_target: assert property (@(posedge clk) disable iff (rst)
        jr_sel |=> pc_o == $past(rs_val));

    // R6: a register jump changes no storage
    a_r6_jr_no_write: assert property (@(posedge clk) disable iff (rst)
        jr_sel |-> (!rf_we && !dm_we));

    // R4: a store writes no register
    a_r4_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        store_op |-> !rf_we);

    // R8: register zero reads as zero
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> rs_val == 32'd0);

endmodule

bind scpu_core scpu_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .jr_sel      (jr_sel),
    .take_branch (take_branch),
    .rf_we       (rf_we),
    .dm_we       (dm_we),
    .store_op    (dm_we),
    .rs_idx      (rs_idx),
    .rs_val      (rs_val)
);

// File: tb/sim_scpu_core.sv
`timescale 1ns/1ps
module sim_scpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic        prog_dmem = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic [31:0] pc_o;
    logic [4:0]  peek_reg_sel = '0;
    logic [31:0] peek_reg_val;
    logic [5:0]  peek_mem_sel = '0;
    logic [31:0] peek_mem_val;

    int checks = 0;
    int errors = 0;
    logic [31:0] prog [16];

    always #2.5 clk = ~clk;

    scpu_core u0 (
        .clk          (clk),
        .rst          (rst),
        .prog_we      (prog_we),
        .prog_dmem    (prog_dmem),
        .prog_addr    (prog_addr),
        .prog_wdata   (prog_wdata),
        .pc_o         (pc_o),
        .peek_reg_sel (peek_reg_sel),
        .peek_reg_val (peek_reg_val),
        .peek_mem_sel (peek_mem_sel),
        .peek_mem_val (peek_mem_val)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic reg_is(input string req, input logic [4:0] r, input logic [31:0] exp);
        peek_reg_sel = r;
        #0.1;
        chk(req, peek_reg_val, exp);
    endtask

    task automatic mem_is(input string req, input logic [5:0] a, input logic [31:0] exp);
        peek_mem_sel = a;
        #0.1;
        chk(req, peek_mem_val, exp);
    endtask

    task automatic put_word(input logic dm, input int a, input logic [31:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_dmem = dm; prog_addr = 6'(a); prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // hold reset, fill instruction memory, then release at a falling edge
    task automatic load_and_start(input int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) put_word(1'b0, i, (i < n) ? prog[i] : 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_alu;
        put_word(1'b1, 0, 32'd7);
        put_word(1'b1, 1, 32'hFFFF_FFFD);
        prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
        prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
        prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
        prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
        prog[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
        prog[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
        prog[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
        prog[9]  = enc_i(6'h0F, 5'd0, 5'd9, 16'hABCD);
        prog[10] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
        load_and_start(11);
        chk("R1 pc after reset", pc_o, 32'd0);
        for (int k = 1; k <= 3; k++) begin
            step();
            chk("R9 sequential pc", pc_o, 32'(4 * k));
        end
        repeat (12) step();
        chk("R9 loop pc", pc_o, 32'd40);
        reg_is("R3 lw r1", 5'd1, 32'd7);
        reg_is("R3 lw r2", 5'd2, 32'hFFFF_FFFD);
        reg_is("R2 add", 5'd3, 32'd7 + 32'hFFFF_FFFD);
        reg_is("R2 sub", 5'd4, 32'd7 - 32'hFFFF_FFFD);
        reg_is("R2 and", 5'd5, 32'd7 & 32'hFFFF_FFFD);
        reg_is("R2 or", 5'd6, 32'd7 | 32'hFFFF_FFFD);
        reg_is("R2 slt true", 5'd7, 32'd1);
        reg_is("R2 slt false", 5'd8, 32'd0);
        reg_is("R8 r0 stays zero", 5'd0, 32'd0);
        reg_is("R7 lui", 5'd9, 32'hABCD_0000);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) step();
        chk("R1 pc held in reset", pc_o, 32'd0);
        reg_is("R1 reg cleared", 5'd1, 32'd0);
        reg_is("R1 reg cleared", 5'd9, 32'd0);
    endtask

    task automatic t_mem;
        put_word(1'b1, 2, 32'h1111_1111);
        put_word(1'b1, 3, 32'd20);
        put_word(1'b1, 4, 32'h2222_2222);
        prog[0] = enc_i(6'h0F, 5'd0, 5'd1, 16'hCAFE);
        prog[1] = enc_i(6'h2B, 5'd0, 5'd1, 16'd8);
        prog[2] = enc_i(6'h23, 5'd0, 5'd2, 16'd8);
        prog[3] = enc_i(6'h08, 5'd0, 5'd3, 16'd5);
        prog[4] = enc_i(6'h23, 5'd0, 5'd4, 16'd12);
        prog[5] = enc_i(6'h2B, 5'd4, 5'd2, 16'hFFFC);
        prog[6] = enc_i(6'h23, 5'd0, 5'd5, 16'd16);
        prog[7] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
        load_and_start(8);
        repeat (12) step();
        chk("R10 pc continues past unknown op", pc_o, 32'd28);
        reg_is("R4 store leaves rt intact", 5'd1, 32'hCAFE_0000);
        mem_is("R4 store word", 6'd2, 32'hCAFE_0000);
        reg_is("R3 load after store", 5'd2, 32'hCAFE_0000);
        reg_is("R10 unknown op writes nothing", 5'd3, 32'd0);
        mem_is("R4 negative offset store", 6'd4, 32'hCAFE_0000);
        reg_is("R3 load of stored word", 5'd5, 32'hCAFE_0000);
        mem_is("R10 other word untouched", 6'd3, 32'd20);
    endtask

    task automatic t_flow;
        logic [31:0] trace [10];
        trace = '{32'd0, 32'd4, 32'd8, 32'd20, 32'd24, 32'd28, 32'd32, 32'd40, 32'd44, 32'd44};
        put_word(1'b1, 0, 32'd7);
        put_word(1'b1, 1, 32'd40);
        prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd0);
        prog[2]  = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
        prog[3]  = enc_i(6'h0F, 5'd0, 5'd3, 16'h1111);
        prog[4]  = enc_i(6'h0F, 5'd0, 5'd3, 16'h2222);
        prog[5]  = enc_i(6'h04, 5'd1, 5'd0, 16'd1);
        prog[6]  = enc_i(6'h0F, 5'd0, 5'd4, 16'h3333);
        prog[7]  = enc_i(6'h23, 5'd0, 5'd5, 16'd4);
        prog[8]  = enc_r(5'd5, 5'd0, 5'd0, 6'h08);
        prog[9]  = enc_i(6'h0F, 5'd0, 5'd6, 16'h4444);
        prog[10] = enc_i(6'h0F, 5'd0, 5'd7, 16'h5555);
        prog[11] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
        load_and_start(12);
        for (int k = 1; k < 10; k++) begin
            step();
            if (k == 3)      chk("R5 taken branch pc", pc_o, trace[k]);
            else if (k == 4) chk("R5 untaken branch pc", pc_o, trace[k]);
            else if (k == 7) chk("R6 jump register pc", pc_o, trace[k]);
            else             chk("R9 flow trace pc", pc_o, trace[k]);
        end
        reg_is("R5 skipped instruction", 5'd3, 32'd0);
        reg_is("R5 fall-through executed", 5'd4, 32'h3333_0000);
        reg_is("R6 skipped after jump", 5'd6, 32'd0);
        reg_is("R6 jump target executed", 5'd7, 32'h5555_0000);
        mem_is("R6 no memory write", 6'd1, 32'd40);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        t_alu();
        t_reset();
        t_mem();
        t_flow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule